// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words from a host into asynchronous serial frames on a single output line. A one-word holding register sits in front of the shift engine. The host can therefore queue the next word while the current one is still on the line. Frames then follow each other with no idle bit between them. A word is 8 bits wide, or 9 bits when wide mode is selected. The extra top bit comes from a separately written ninth-bit register, which lets a multi-drop link flag address words.

Bit timing comes entirely from an external one-cycle baud tick. The block has two separate status flags. The holding-empty flag tells the host when it may write again, and it can also raise an interrupt. The shift-empty flag tells the host when the line has fully drained, and software polls it. Dropping the enable aborts everything and returns the block to a quiet state.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, `tx_line` is 1, `hold_empty` is 0, `shift_empty` is 1, `overrun` is 0 and `irq` is 0.
- R2: The first clock edge that samples `tx_en` high sets `hold_empty` (the holding register is empty). `irq` is registered and equals `hold_empty` AND `irq_en`, with both taken from the same clock edge.
- R3: The line idles at 1. Each frame consists of a start bit at 0, then the data bits with the least significant bit first, then a stop bit at 1. The line changes only on a clock edge that samples `baud_tick` high, or when the block is disabled. The start bit begins at the first tick after a word enters the shift engine.
- R4: When `wide_mode` is 1 at the time of the byte write, nine data bits are sent. The ninth bit goes out after bit 7 and carries the value the ninth-bit register held when the byte was written. A later write to that register does not change a word that has already been queued. When `wide_mode` is 0, exactly eight data bits are sent.
- R5: Suppose the block is enabled and idle, and a byte write is sampled at edge k. Then after edge k, `hold_empty` is 0 and `shift_empty` is 1. After edge k+1, `hold_empty` is 1 and `shift_empty` is 0.
- R6: `shift_empty` stays 0 for the whole stop bit. It returns to 1 at the tick that ends the stop bit, exactly one tick period after the stop bit began, when no word is waiting.
- R7: A word written while another word is shifting waits in the holding register, and `hold_empty` stays 0 meanwhile. The waiting word enters the shift engine at the tick that ends the previous stop bit, and its start bit begins at that same tick, so there are zero idle bits between the frames.
- R8: A byte write while the holding register is full is ignored, and the queued word is sent unchanged. Such a write sets `overrun`, which then stays 1 while the block remains enabled.
- R9: While `tx_en` is 0, the block drives `tx_line` to 1, `shift_empty` to 1, and `hold_empty`, `irq` and `overrun` to 0. Deasserting `tx_en` aborts the current frame and discards any waiting word. Byte writes made while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low aborts and clears |
| wide_mode | input | 1 | 1 selects 9-bit words; captured with each byte write |
| irq_en | input | 1 | Interrupt enable for the holding-empty flag |
| bit9_wr | input | 1 | Write strobe for the ninth-bit register |
| bit9_din | input | 1 | Value for the ninth-bit register |
| data_wr | input | 1 | Byte write strobe into the holding register |
| data_in | input | DATA_W | Byte to queue |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_line | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register is empty and the block is enabled |
| shift_empty | output | 1 | Shift engine holds no character (polled) |
| overrun | output | 1 | Sticky flag for a write dropped while the holding register was full |
| irq | output | 1 | Registered hold_empty AND irq_en |

## Verification
Every status flag is registered. A write strobe sampled at edge k therefore shows up on `hold_empty` after edge k, and the transfer into the shift engine shows up one edge later. The bench drives its inputs and reads the outputs on the falling edge, then checks the flags at exactly those two half-periods. The line changes only at tick edges, so the bench decodes frames by sampling `tx_line` on the falling edge that follows each tick. It times the rise of `shift_empty` against the cycle at which the stop bit was captured, and requires a gap of exactly one tick period. Back-to-back behaviour is judged by counting idle bits between decoded frames, which must be zero.

// File: rtl/serial_tx_dbuf_pkg.sv
package serial_tx_dbuf_pkg;
  typedef enum logic [1:0] {
    ENG_EMPTY  = 2'd0,
    ENG_PEND   = 2'd1,
    ENG_ACTIVE = 2'd2
  } eng_state_t;
endpackage

// File: rtl/serial_tx_dbuf_hold.sv
module serial_tx_dbuf_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              irq_en,
  input  logic              bit9_wr,
  input  logic              bit9_din,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic              mode,
  input  logic              take,
  output logic              full,
  output logic [DATA_W:0]   word,
  output logic              wide,
  output logic              hold_empty,
  output logic              irq,
  output logic              overrun
);
  logic full_nxt;
  logic ninth_q;

  always_comb begin
    full_nxt = full;
    if (!en)                full_nxt = 1'b0;
    else if (take)          full_nxt = 1'b0;
    else if (wr && !full)   full_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full       <= 1'b0;
      word       <= '0;
      wide       <= 1'b0;
      hold_empty <= 1'b0;
      irq        <= 1'b0;
      overrun    <= 1'b0;
      ninth_q    <= 1'b0;
    end else begin
      full       <= full_nxt;
      hold_empty <= en && !full_nxt;
      irq        <= en && !full_nxt && irq_en;
      if (bit9_wr) ninth_q <= bit9_din;
      if (!en)               overrun <= 1'b0;
      else if (wr && full)   overrun <= 1'b1;
      if (en && wr && !full) begin
        word <= {ninth_q, din};
        wide <= mode;
      end
    end
  end

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $past(overrun)) |-> overrun); // R8
  AST_FULL_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
    $past(full) |-> $stable(word)); // R8
  AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    irq |-> hold_empty); // R2
endmodule

// File: rtl/serial_tx_dbuf_shift.sv
module serial_tx_dbuf_shift
  import serial_tx_dbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            have_word,
  input  logic [DATA_W:0] word,
  input  logic            wide,
  output logic            take,
  output logic            txd,
  output logic            sh_empty
);
  localparam int CNT_W  = $clog2(DATA_W + 3);
  localparam int STOP8  = DATA_W + 1;
  localparam int STOP9  = DATA_W + 2;

  eng_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W:0]   sreg;
  logic              wide_q;
  logic [CNT_W-1:0]  stop_idx;
  logic              at_stop_end;

  assign stop_idx    = wide_q ? CNT_W'(STOP9) : CNT_W'(STOP8);
  assign at_stop_end = (st == ENG_ACTIVE) && tick && (cnt == stop_idx);
  assign take        = have_word && en && ((st == ENG_EMPTY) || at_stop_end);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st       <= ENG_EMPTY;
      cnt      <= '0;
      sreg     <= '0;
      wide_q   <= 1'b0;
      txd      <= 1'b1;
      sh_empty <= 1'b1;
    end else begin
      case (st)
        ENG_EMPTY: begin
          if (take) begin
            sreg     <= word;
            wide_q   <= wide;
            st       <= ENG_PEND;
            sh_empty <= 1'b0;
          end
        end
        ENG_PEND: begin
          if (tick) begin
            txd <= 1'b0;
            cnt <= '0;
            st  <= ENG_ACTIVE;
          end
        end
        ENG_ACTIVE: begin
          if (tick) begin
            if (cnt == stop_idx) begin
              if (take) begin
                sreg   <= word;
                wide_q <= wide;
                txd    <= 1'b0;
                cnt    <= '0;
              end else begin
                st       <= ENG_EMPTY;
                txd      <= 1'b1;
                sh_empty <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
              if (cnt == stop_idx - 1'b1) begin
                txd <= 1'b1;
              end else begin
                txd  <= sreg[0];
                sreg <= sreg >> 1;
              end
            end
          end
        end
        default: st <= ENG_EMPTY;
      endcase
    end
  end

  AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(tick) && !$past(rst)) |-> $stable(txd)); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst) && $past(tick) && ($past(st) == ENG_PEND)) |-> !txd); // R3
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    sh_empty |-> txd); // R6
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              wide_mode,
  input  logic              irq_en,
  input  logic              bit9_wr,
  input  logic              bit9_din,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              baud_tick,
  output logic              tx_line,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              overrun,
  output logic              irq
);
  logic            full;
  logic            take;
  logic [DATA_W:0] word;
  logic            wide;

  serial_tx_dbuf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .en         (tx_en),
    .irq_en     (irq_en),
    .bit9_wr    (bit9_wr),
    .bit9_din   (bit9_din),
    .wr         (data_wr),
    .din        (data_in),
    .mode       (wide_mode),
    .take       (take),
    .full       (full),
    .word       (word),
    .wide       (wide),
    .hold_empty (hold_empty),
    .irq        (irq),
    .overrun    (overrun)
  );

  serial_tx_dbuf_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_en),
    .tick      (baud_tick),
    .have_word (full),
    .word      (word),
    .wide      (wide),
    .take      (take),
    .txd       (tx_line),
    .sh_empty  (shift_empty)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_en) |-> (tx_line && shift_empty && !hold_empty && !irq && !overrun)); // R9
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    full |-> !hold_empty); // R5
endmodule

// File: tb/serial_tx_dbuf_bench.sv
module serial_tx_dbuf_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst, tx_en, wide_mode, irq_en, bit9_wr, bit9_din, data_wr, baud_tick;
  logic [7:0] data_in;
  logic       tx_line, hold_empty, shift_empty, overrun, irq;

  int     n_chk = 0, n_err = 0;
  bit     done = 0;
  longint cyc = 0, stop_cyc = 0;
  int     tickcnt = 0;
  logic   tick_q = 1'b0;

  // frame decoder state
  int       nb_exp = 8;
  int       fr_n = 0, gap = 0, bitn = 0;
  bit       in_fr = 0;
  logic [8:0] acc;
  logic [8:0] fr_data [0:15];
  bit       fr_stop [0:15];
  int       fr_gap  [0:15];

  always #10 clk = ~clk;

  serial_tx_dbuf u_serial_tx_dbuf (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wide_mode(wide_mode), .irq_en(irq_en),
    .bit9_wr(bit9_wr), .bit9_din(bit9_din), .data_wr(data_wr), .data_in(data_in),
    .baud_tick(baud_tick), .tx_line(tx_line), .hold_empty(hold_empty),
    .shift_empty(shift_empty), .overrun(overrun), .irq(irq)
  );

  always @(negedge clk) begin
    tickcnt <= (tickcnt == DIV - 1) ? 0 : tickcnt + 1;
    baud_tick <= (tickcnt == DIV - 1);
  end

  always @(posedge clk) begin
    tick_q <= baud_tick;
    cyc    <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst || !tx_en) begin
      in_fr = 0;
    end else if (tick_q) begin
      if (!in_fr) begin
        if (!tx_line) begin
          in_fr = 1; bitn = 0; acc = '0;
          if (fr_n < 16) fr_gap[fr_n] = gap;
          gap = 0;
        end else gap++;
      end else if (bitn < nb_exp) begin
        acc[bitn] = tx_line;
        bitn++;
      end else begin
        if (fr_n < 16) begin
          fr_data[fr_n] = acc;
          fr_stop[fr_n] = tx_line;
        end
        fr_n++;
        stop_cyc = cyc;
        in_fr = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic m);
    wide_mode = m; data_in = d; data_wr = 1'b1;
    step();
    data_wr = 1'b0;
  endtask

  task automatic wait_done(output int diff);
    for (int i = 0; i < 400; i++) begin
      if (shift_empty && hold_empty) break;
      step();
    end
    diff = int'(cyc - stop_cyc);
  endtask

  task automatic t_reset();
    rst = 1; tx_en = 0; wide_mode = 0; irq_en = 0; bit9_wr = 0; bit9_din = 0;
    data_wr = 0; data_in = 0;
    repeat (3) step();
    rst = 0;
    step();
    chk("R1", "tx_line", tx_line, 1);
    chk("R1", "hold_empty", hold_empty, 0);
    chk("R1", "shift_empty", shift_empty, 1);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_enable();
    tx_en = 1; step();
    chk("R2", "hold_empty after enable", hold_empty, 1);
    chk("R2", "irq masked", irq, 0);
    irq_en = 1; step();
    chk("R2", "irq enabled", irq, 1);
    irq_en = 0; step();
    chk("R2", "irq masked again", irq, 0);
  endtask

  task automatic t_frame8();
    int diff;
    nb_exp = 8; fr_n = 0;
    wr_byte(8'h5A, 1'b0);
    chk("R5", "hold_empty after write", hold_empty, 0);
    chk("R5", "shift_empty after write", shift_empty, 1);
    step();
    chk("R5", "hold_empty after transfer", hold_empty, 1);
    chk("R5", "shift_empty after transfer", shift_empty, 0);
    wait_done(diff);
    chk("R3", "frame count", fr_n, 1);
    chk("R3", "data 5A", int'(fr_data[0][7:0]), 8'h5A);
    chk("R3", "stop bit", int'(fr_stop[0]), 1);
    chk("R6", "shift_empty rise after stop", diff, DIV);
    fr_n = 0;
    wr_byte(8'h81, 1'b0);
    wait_done(diff);
    chk("R3", "data 81", int'(fr_data[0][7:0]), 8'h81);
    chk("R6", "rise timing 81", diff, DIV);
    chk("R3", "idle line", tx_line, 1);
  endtask

  task automatic t_nine();
    int diff;
    nb_exp = 9; fr_n = 0;
    bit9_din = 1; bit9_wr = 1; step(); bit9_wr = 0;
    wr_byte(8'hA5, 1'b1);
    bit9_din = 0; bit9_wr = 1; step(); bit9_wr = 0;
    wait_done(diff);
    chk("R4", "nine-bit word 1A5", int'(fr_data[0]), 9'h1A5);
    chk("R4", "stop after ninth", int'(fr_stop[0]), 1);
    chk("R4", "rise timing 9-bit", diff, DIV);
    fr_n = 0;
    wr_byte(8'h3C, 1'b1);
    wait_done(diff);
    chk("R4", "nine-bit word 03C", int'(fr_data[0]), 9'h03C);
    nb_exp = 8; fr_n = 0;
    bit9_din = 1; bit9_wr = 1; step(); bit9_wr = 0;
    wr_byte(8'h0F, 1'b0);
    wait_done(diff);
    chk("R4", "eight-bit word length", diff, DIV);
    chk("R4", "eight-bit data", int'(fr_data[0][7:0]), 8'h0F);
  endtask

  task automatic t_b2b();
    int diff;
    nb_exp = 8; fr_n = 0;
    wr_byte(8'h33, 1'b0);
    step();
    wr_byte(8'hC4, 1'b0);
    for (int i = 0; i < 400; i++) begin
      if (fr_n >= 1) break;
      step();
    end
    chk("R7", "hold_empty during first stop", hold_empty, 0);
    wait_done(diff);
    chk("R7", "frame count", fr_n, 2);
    chk("R7", "first word", int'(fr_data[0][7:0]), 8'h33);
    chk("R7", "second word", int'(fr_data[1][7:0]), 8'hC4);
    chk("R7", "idle bits between", fr_gap[1], 0);
  endtask

  task automatic t_overrun();
    int diff;
    nb_exp = 8; fr_n = 0;
    wr_byte(8'h96, 1'b0);
    step();
    wr_byte(8'h21, 1'b0);
    chk("R8", "overrun before extra", overrun, 0);
    wr_byte(8'hEE, 1'b0);
    chk("R8", "overrun set", overrun, 1);
    wait_done(diff);
    chk("R8", "frame count", fr_n, 2);
    chk("R8", "first word", int'(fr_data[0][7:0]), 8'h96);
    chk("R8", "queued word unchanged", int'(fr_data[1][7:0]), 8'h21);
    chk("R8", "overrun sticky", overrun, 1);
    tx_en = 0; step();
    chk("R9", "overrun cleared by disable", overrun, 0);
    tx_en = 1; step();
  endtask

  task automatic t_disable();
    nb_exp = 8;
    wr_byte(8'h00, 1'b0);
    step();
    wr_byte(8'h7E, 1'b0);
    repeat (12) step();
    chk("R9", "line low mid frame", tx_line, 0);
    tx_en = 0; irq_en = 1; step();
    chk("R9", "line idle after abort", tx_line, 1);
    chk("R9", "shift_empty after abort", shift_empty, 1);
    chk("R9", "hold_empty after abort", hold_empty, 0);
    chk("R9", "irq while disabled", irq, 0);
    wr_byte(8'h55, 1'b0);
    fr_n = 0;
    tx_en = 1;
    repeat (80) step();
    chk("R9", "no frame after re-enable", fr_n, 0);
    chk("R9", "shift_empty stays", shift_empty, 1);
    chk("R9", "hold_empty after re-enable", hold_empty, 1);
    irq_en = 0;
  endtask

  initial begin
    t_reset();
    t_enable();
    t_frame8();
    t_nine();
    t_b2b();
    t_overrun();
    t_disable();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule